// File: doc/BRIEF.md
# Power Switch Operating Mode Controller

This block decides the operating mode of a two-channel power switch and turns that mode into per-channel on/off commands. It watches a host enable pin and the two direct control inputs to tell whether the device should be awake. It watches the top bit of each received serial word to tell whether the host is still talking. It also takes a supply-fail flag and the fault flags from the protection logic. From these it picks one of four modes: Sleep, Normal, Fail-safe or Fault. It drives two active-low status outputs, one for fail-safe and one for fault.

In Normal mode each channel's command combines the direct input, the register on bit and the PWM duty compare. In Fail-safe mode the direct inputs alone steer the channels. The register bank is held in reset, and writes stay blocked until the host completes a two-word handshake. In Sleep and Fault modes every channel is off. All timeouts are counted in ticks of an input timebase, so the tick counts can be made short for simulation.

Top module: `swmode_ctrl`

## Requirements
- R1: After reset the mode output is Sleep (encoding 2'b00). Both status outputs are high, all channel commands are 0, the register-reset output is 1 and the register-access output is 0.
- R2: The wake condition is the OR of the host pin and the per-channel activity flags. An activity flag rises on the clock edge that samples its direct input high. It falls after IDLE_TICKS ticks with that input low. The mode leaves Sleep on the edge after wake is seen, and returns to Sleep one edge after wake drops.
- R3: Mode encodings are Sleep 2'b00, Normal 2'b01, Fail-safe 2'b10 and Fault 2'b11. When awake, any fault flag gives Fault whatever the fail-safe condition is. The Fault status output is low only in Fault. A Fault entered from Normal does not reset the registers.
- R4: The fail-safe condition is (supply-fail AND supply-fail-enable) OR (watchdog lost AND watchdog-disable = 0). Supply-fail with its enable low has no effect on the mode.
- R5: The watchdog is armed on a rising edge of the host pin. It is lost when WD_TICKS ticks pass without a received word whose top bit differs from the previous word's top bit. Words that repeat the same top bit do not restart the window.
- R6: Fail-safe caused by the watchdog is left only after a word with top bit 1, followed by any word within WD_TICKS ticks. A single word is not enough. A late second word is not enough. A first word with top bit 0 is not enough. Register access (1) is granted only in Normal mode.
- R7: In Normal mode, channel command = (direct input AND direct-enable) OR (on bit AND PWM compare AND PWM enable) OR (on bit AND NOT PWM enable).
- R8: In Fail-safe mode each channel command equals its direct input. The fail-safe status output is low, register-reset is 1 and register access is 0.
- R9: In Sleep and Fault modes all channel commands are 0, whatever the inputs are.
- R10: A fault that appears during Fail-safe gives Fault with the fail-safe status still low and register-reset still 1. When the fault clears, the mode returns to Fail-safe, not Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_i | input | 1 | Host enable pin; high keeps the block awake and its rising edge arms the watchdog |
| din_i | input | NCH | Direct control inputs, one per channel |
| word_stb_i | input | 1 | One-cycle strobe for a completed received word |
| word_msb_i | input | 1 | Top bit of the word flagged by word_stb_i |
| chan_flt_i | input | NCH | Per-channel fault flags |
| glob_flt_i | input | 1 | Fault flag shared by both channels (supply under/over voltage) |
| sup_fail_i | input | 1 | Logic supply failure flag |
| sup_fail_en_i | input | 1 | Lets sup_fail_i cause fail-safe |
| wd_dis_i | input | 1 | Disables the word watchdog |
| tick_i | input | 1 | Timebase tick |
| dir_en_i | input | NCH | Direct input enable per channel |
| on_bit_i | input | NCH | Register on bit per channel |
| pwm_en_i | input | NCH | PWM enable per channel |
| pwm_cmp_i | input | NCH | PWM duty compare result per channel |
| mode_o | output | 2 | Current mode encoding |
| chan_cmd_o | output | NCH | Target on/off command per channel |
| fs_n_o | output | 1 | Fail-safe status, active low |
| flt_n_o | output | 1 | Fault status, active low |
| regs_rst_o | output | 1 | Holds the register bank in reset |
| reg_acc_o | output | 1 | Register writes permitted |

## Verification
The channel command equation is driven through a table of input combinations. Each term of the equation is the only true term in at least one row, and the masking factors (direct-enable low, PWM enable high with the compare low, on bit low) each appear as the deciding input. The watchdog gets three patterns: alternating top bits, which must keep Normal; a steady stream of same-bit words, which must still time out; and silence. This shows that alternation, not traffic, feeds the watchdog. The fail-safe exit is tried with a wrong first word, a lone first word, a second word that comes too late and a correct pair, so each rule of the handshake is tested on its own. Fault and fail-safe are raised together and then cleared one at a time to expose the decode priority and the return path. The activity timeout is sampled one tick before and one tick after its limit.

// File: rtl/swmode_pkg.sv
package swmode_pkg;

  // Mode encoding is visible on mode_o (R3).
  typedef enum logic [1:0] {
    MODE_SLEEP    = 2'b00,
    MODE_NORMAL   = 2'b01,
    MODE_FAILSAFE = 2'b10,
    MODE_FAULT    = 2'b11
  } mode_e;

  // Watchdog / handshake progress.
  typedef enum logic [1:0] {
    WD_RUN  = 2'b00,   // link alive, window counting
    WD_LOST = 2'b01,   // timed out, waiting for a word with top bit 1
    WD_HALF = 2'b10    // first handshake word seen, waiting for the second
  } wd_state_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/swmode_actmon.sv
// Activity flag for one direct input (R2).
module swmode_actmon #(
  parameter int unsigned IDLE_TICKS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic din_i,
  output logic act_o
);
  import swmode_pkg::*;

  localparam int unsigned CW = cnt_width(IDLE_TICKS);
  localparam logic [CW-1:0] LAST = CW'(IDLE_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          cnt_en;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (din_i) begin
      act_d  = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (tick_i && act_q) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign act_o = act_q;

endmodule

// File: rtl/swmode_wdog.sv
// Top-bit alternation watchdog with two-word recovery handshake (R5, R6).
module swmode_wdog #(
  parameter int unsigned WD_TICKS = 310
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic host_i,
  input  logic wd_dis_i,
  input  logic stb_i,
  input  logic msb_i,
  output logic lost_o
);
  import swmode_pkg::*;

  localparam int unsigned CW = cnt_width(WD_TICKS);
  localparam logic [CW-1:0] LAST = CW'(WD_TICKS - 1);

  wd_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_q, last_d;
  logic          armed_q, armed_d;
  logic          host_q;
  logic          host_rise;
  logic          window_end;

  assign host_rise  = host_i && !host_q;
  assign window_end = tick_i && (cnt_q == LAST);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    last_d  = last_q;
    armed_d = armed_q;
    if (!host_i) begin
      armed_d = 1'b0;
      st_d    = WD_RUN;
      cnt_d   = '0;
    end else if (host_rise) begin
      armed_d = 1'b1;
      st_d    = WD_RUN;
      cnt_d   = '0;
      last_d  = 1'b0;
    end else if (wd_dis_i) begin
      st_d  = WD_RUN;
      cnt_d = '0;
    end else if (armed_q) begin
      unique case (st_q)
        WD_RUN: begin
          if (stb_i && (msb_i != last_q)) begin
            cnt_d  = '0;
            last_d = msb_i;
          end else if (window_end) begin
            st_d  = WD_LOST;
            cnt_d = '0;
          end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        WD_LOST: begin
          if (stb_i && msb_i) begin
            st_d   = WD_HALF;
            cnt_d  = '0;
            last_d = 1'b1;
          end
        end
        WD_HALF: begin
          if (stb_i) begin
            st_d   = WD_RUN;
            cnt_d  = '0;
            last_d = msb_i;
          end else if (window_end) begin
            st_d  = WD_LOST;
            cnt_d = '0;
          end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = WD_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WD_RUN;
      cnt_q   <= '0;
      last_q  <= 1'b0;
      armed_q <= 1'b0;
      host_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
      armed_q <= armed_d;
      host_q  <= host_i;
    end
  end

  assign lost_o = armed_q && (st_q != WD_RUN);

endmodule

// File: rtl/swmode_chcmd.sv
// Per-channel target command from the current mode (R7, R8, R9).
module swmode_chcmd #(
  parameter int unsigned NCH = 2
) (
  input  swmode_pkg::mode_e mode_i,
  input  logic [NCH-1:0]    din_i,
  input  logic [NCH-1:0]    dir_en_i,
  input  logic [NCH-1:0]    on_bit_i,
  input  logic [NCH-1:0]    pwm_en_i,
  input  logic [NCH-1:0]    pwm_cmp_i,
  output logic [NCH-1:0]    cmd_o
);
  import swmode_pkg::*;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic reg_path;
    logic norm_cmd;

    assign reg_path = on_bit_i[c] && (pwm_en_i[c] ? pwm_cmp_i[c] : 1'b1);
    assign norm_cmd = (din_i[c] && dir_en_i[c]) || reg_path;

    always_comb begin
      unique case (mode_i)
        MODE_NORMAL:   cmd_o[c] = norm_cmd;
        MODE_FAILSAFE: cmd_o[c] = din_i[c];
        default:       cmd_o[c] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/swmode_ctrl.sv
// Operating mode controller for a two-channel power switch.
module swmode_ctrl #(
  parameter int unsigned NCH        = 2,
  parameter int unsigned IDLE_TICKS = 250,
  parameter int unsigned WD_TICKS   = 310
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_i,
  input  logic [NCH-1:0] din_i,
  input  logic           word_stb_i,
  input  logic           word_msb_i,
  input  logic [NCH-1:0] chan_flt_i,
  input  logic           glob_flt_i,
  input  logic           sup_fail_i,
  input  logic           sup_fail_en_i,
  input  logic           wd_dis_i,
  input  logic           tick_i,
  input  logic [NCH-1:0] dir_en_i,
  input  logic [NCH-1:0] on_bit_i,
  input  logic [NCH-1:0] pwm_en_i,
  input  logic [NCH-1:0] pwm_cmp_i,
  output logic [1:0]     mode_o,
  output logic [NCH-1:0] chan_cmd_o,
  output logic           fs_n_o,
  output logic           flt_n_o,
  output logic           regs_rst_o,
  output logic           reg_acc_o
);
  import swmode_pkg::*;

  logic [NCH-1:0] act;
  logic           wd_lost;
  logic           wake, fs_cond, flt_cond;
  mode_e          mode_q, mode_d;
  logic           fs_q;

  // Activity monitors, one per direct input (R2).
  for (genvar c = 0; c < NCH; c++) begin : g_act
    swmode_actmon #(.IDLE_TICKS(IDLE_TICKS)) u_act (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .din_i  (din_i[c]),
      .act_o  (act[c])
    );
  end

  swmode_wdog #(.WD_TICKS(WD_TICKS)) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .host_i   (host_i),
    .wd_dis_i (wd_dis_i),
    .stb_i    (word_stb_i),
    .msb_i    (word_msb_i),
    .lost_o   (wd_lost)
  );

  // Combined conditions (R2, R3, R4).
  assign wake     = host_i || (|act);
  assign fs_cond  = (sup_fail_i && sup_fail_en_i) || (wd_lost && !wd_dis_i);
  assign flt_cond = (|chan_flt_i) || glob_flt_i;

  // Mode decode with fault priority (R3).
  always_comb begin
    if (!wake)        mode_d = MODE_SLEEP;
    else if (flt_cond) mode_d = MODE_FAULT;
    else if (fs_cond)  mode_d = MODE_FAILSAFE;
    else               mode_d = MODE_NORMAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SLEEP;
      fs_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      fs_q   <= fs_cond && wake;
    end
  end

  swmode_chcmd #(.NCH(NCH)) u_cmd (
    .mode_i    (mode_q),
    .din_i     (din_i),
    .dir_en_i  (dir_en_i),
    .on_bit_i  (on_bit_i),
    .pwm_en_i  (pwm_en_i),
    .pwm_cmp_i (pwm_cmp_i),
    .cmd_o     (chan_cmd_o)
  );

  // Status and register control (R1, R8, R10).
  assign mode_o     = mode_q;
  assign fs_n_o     = !((mode_q == MODE_FAILSAFE) || ((mode_q == MODE_FAULT) && fs_q));
  assign flt_n_o    = (mode_q != MODE_FAULT);
  assign regs_rst_o = (mode_q == MODE_SLEEP) || fs_q;
  assign reg_acc_o  = (mode_q == MODE_NORMAL);

endmodule

// File: rtl/swmode_ctrl_chk.sv
module swmode_ctrl_chk #(
  parameter int unsigned NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           host_i,
  input logic [NCH-1:0] din_i,
  input logic [NCH-1:0] chan_flt_i,
  input logic           glob_flt_i,
  input logic [1:0]     mode_o,
  input logic [NCH-1:0] chan_cmd_o,
  input logic           fs_n_o,
  input logic           flt_n_o,
  input logic           reg_acc_o
);

  assert_sleep_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00) |-> (chan_cmd_o == '0))
    else $error("sleep mode with a channel on");

  assert_fault_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11) |-> (!flt_n_o && (chan_cmd_o == '0)))
    else $error("fault mode outputs wrong");

  assert_failsafe_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10) |-> ((chan_cmd_o == din_i) && !fs_n_o && !reg_acc_o))
    else $error("fail-safe outputs wrong");

  assert_host_wakes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_i |=> (mode_o != 2'b00))
    else $error("host pin high but still asleep");

  assert_fault_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_i && ((|chan_flt_i) || glob_flt_i)) |=> (mode_o == 2'b11))
    else $error("fault did not take priority");

endmodule

bind swmode_ctrl swmode_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_i     (host_i),
  .din_i      (din_i),
  .chan_flt_i (chan_flt_i),
  .glob_flt_i (glob_flt_i),
  .mode_o     (mode_o),
  .chan_cmd_o (chan_cmd_o),
  .fs_n_o     (fs_n_o),
  .flt_n_o    (flt_n_o),
  .reg_acc_o  (reg_acc_o)
);

// File: tb/sim_swmode_ctrl.sv
`timescale 1ns/1ps
module sim_swmode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 2;
  localparam int IDLE = 8;
  localparam int WDT  = 12;
  localparam int NVEC = 6;
  // vec[11:10] expected cmd {ch1,ch0}; vec[9:5] ch1, vec[4:0] ch0
  // each channel field = {din, dir_en, on_bit, pwm_en, pwm_cmp}
  localparam logic [11:0] VEC [NVEC] = '{12'hB10, 12'h8E6, 12'hCA4,
                                         12'h00B, 12'hDBF, 12'h2C3};

  logic clk = 1'b0;
  logic rst_n;
  logic host, stb, msb, gflt, sfail, sfail_en, wd_dis, tick;
  logic [NCH-1:0] din, cflt, den, onb, pen, pcmp;
  logic [1:0] mode;
  logic [NCH-1:0] cmd;
  logic fs_n, flt_n, regs_rst, reg_acc;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swmode_ctrl #(.NCH(NCH), .IDLE_TICKS(IDLE), .WD_TICKS(WDT)) u0 (
    .clk(clk), .rst_n(rst_n), .host_i(host), .din_i(din),
    .word_stb_i(stb), .word_msb_i(msb), .chan_flt_i(cflt), .glob_flt_i(gflt),
    .sup_fail_i(sfail), .sup_fail_en_i(sfail_en), .wd_dis_i(wd_dis),
    .tick_i(tick), .dir_en_i(den), .on_bit_i(onb), .pwm_en_i(pen),
    .pwm_cmp_i(pcmp), .mode_o(mode), .chan_cmd_o(cmd), .fs_n_o(fs_n),
    .flt_n_o(flt_n), .regs_rst_o(regs_rst), .reg_acc_o(reg_acc));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic word(input logic m);
    @(negedge clk); stb = 1'b1; msb = m;
    @(negedge clk); stb = 1'b0; msb = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host = 0; stb = 0; msb = 0; gflt = 0; sfail = 0;
    sfail_en = 0; wd_dis = 0; tick = 1; din = '0; cflt = '0; den = '0;
    onb = 2'b11; pen = '0; pcmp = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 / R9: reset state, on bits set but Sleep keeps channels off
    chk("R1", "mode", 32'(mode), 32'h0);
    chk("R1", "fs_n", 32'(fs_n), 32'h1);
    chk("R1", "flt_n", 32'(flt_n), 32'h1);
    chk("R9", "cmd in sleep", 32'(cmd), 32'h0);
    chk("R1", "regs_rst", 32'(regs_rst), 32'h1);
    chk("R1", "reg_acc", 32'(reg_acc), 32'h0);

    // R2: host pin wakes to Normal
    onb = '0; wd_dis = 1'b1; host = 1'b1;
    cyc(2);
    chk("R2", "mode after host", 32'(mode), 32'h1);
    chk("R6", "reg_acc in normal", 32'(reg_acc), 32'h1);

    // R7: command equation table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {din[1], den[1], onb[1], pen[1], pcmp[1]} = VEC[i][9:5];
      {din[0], den[0], onb[0], pen[0], pcmp[0]} = VEC[i][4:0];
      #1;
      chk("R7", $sformatf("vector %0d", i), 32'(cmd), 32'(VEC[i][11:10]));
    end
    din = '0; den = '0; onb = '0; pen = '0; pcmp = '0;

    // R4: watchdog disabled, long silence stays Normal
    cyc(3 * WDT);
    chk("R4", "wd disabled", 32'(mode), 32'h1);
    // R4: supply fail without enable is ignored
    sfail = 1'b1; cyc(3);
    chk("R4", "sfail no enable", 32'(mode), 32'h1);
    sfail_en = 1'b1; cyc(2);
    chk("R4", "sfail enabled", 32'(mode), 32'h2);
    // R8: fail-safe follows direct inputs only
    din = 2'b01; onb = 2'b11; cyc(1); #1;
    chk("R8", "cmd in failsafe", 32'(cmd), 32'h1);
    chk("R8", "fs_n", 32'(fs_n), 32'h0);
    chk("R8", "regs_rst", 32'(regs_rst), 32'h1);
    chk("R8", "reg_acc", 32'(reg_acc), 32'h0);
    // R10 / R3: fault during fail-safe
    cflt = 2'b01; cyc(2);
    chk("R3", "fault over failsafe", 32'(mode), 32'h3);
    chk("R10", "fs_n in fault", 32'(fs_n), 32'h0);
    chk("R10", "regs_rst in fault", 32'(regs_rst), 32'h1);
    chk("R9", "cmd in fault", 32'(cmd), 32'h0);
    chk("R9", "flt_n", 32'(flt_n), 32'h0);
    cflt = '0; cyc(2);
    chk("R10", "back to failsafe", 32'(mode), 32'h2);
    sfail = 1'b0; cyc(2);
    chk("R4", "sfail cleared", 32'(mode), 32'h1);
    // R3: fault from Normal leaves registers alone
    gflt = 1'b1; cyc(2);
    chk("R3", "shared fault", 32'(mode), 32'h3);
    chk("R3", "fs_n high", 32'(fs_n), 32'h1);
    chk("R3", "regs kept", 32'(regs_rst), 32'h0);
    gflt = 1'b0; din = '0; onb = '0;

    // R2: drop host, activity ends, Sleep
    host = 1'b0; cyc(IDLE + 4);
    chk("R2", "sleep after idle", 32'(mode), 32'h0);
    // R2: exact activity window
    @(negedge clk); din = 2'b01;
    @(negedge clk); din = 2'b00;
    repeat (IDLE - 1) @(posedge clk);
    @(negedge clk);
    chk("R2", "awake before limit", 32'(mode), 32'h1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2", "asleep after limit", 32'(mode), 32'h0);

    // R5: armed by host rise, alternating top bit keeps link
    wd_dis = 1'b0; host = 1'b1; cyc(1);
    for (int k = 0; k < 8; k++) begin
      word(k[0] ? 1'b0 : 1'b1);
      cyc(3);
    end
    chk("R5", "alternating keeps normal", 32'(mode), 32'h1);
    // R5: same top bit repeated does not feed the watchdog
    for (int k = 0; k < 6; k++) begin
      word(1'b0);
      cyc(3);
    end
    chk("R5", "repeated bit times out", 32'(mode), 32'h2);

    // R6: handshake
    word(1'b0); cyc(3);
    chk("R6", "first word top bit 0", 32'(mode), 32'h2);
    word(1'b1); cyc(3);
    chk("R6", "single word", 32'(mode), 32'h2);
    chk("R6", "no access yet", 32'(reg_acc), 32'h0);
    word(1'b0); cyc(2);
    chk("R6", "pair completes", 32'(mode), 32'h1);
    chk("R6", "access granted", 32'(reg_acc), 32'h1);
    cyc(2 * WDT);
    chk("R5", "silence times out", 32'(mode), 32'h2);
    word(1'b1); cyc(WDT + 4);
    word(1'b0); cyc(2);
    chk("R6", "late second word", 32'(mode), 32'h2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule